// File: doc/BRIEF.md
# Preamble-and-Sync Packet Framer with Transition Encoder

This block builds the complete transmit byte stream for a short data burst and hands it, one byte at a time, to a modem transmit FIFO. After a start pulse it emits a fixed 12-byte lead-in: a run of alternating-bit bytes followed by a five-byte sync word. It then forwards either one or two 14-byte coded blocks, which it pulls from an upstream byte stream. A mode input, sampled at start, selects one or two blocks.

Each byte of the assembled packet, lead-in included, goes through a transition encoder before it leaves the block. The encoder reads bits most significant first and emits a 1 wherever a bit differs from the bit before it. The previous-bit state starts at 1 for every packet. A fixed number of leading bit slots is forced to 0 so that the receiver can settle, and the encoder state runs on through those slots and across the block boundary of a two-block packet.

The packet length is reported in two forms for the FIFO: the total byte count, and that count minus one. Both totals are even, so the FIFO can be loaded in 16-bit pairs. Backpressure from the FIFO side holds the current output byte and freezes all encoder state.

Top module: `pf_framer`

## Requirements
- R1: After reset, out_valid, in_ready and busy are 0.
- R2: The unencoded packet starts with seven bytes of 0x55 followed by 0x07, 0x09, 0x2A, 0x44, 0x6F, in that order.
- R3: Bits are taken MSB first, byte after byte. Each output bit is 1 exactly when its source bit differs from the source bit before it. The state before the first bit of a packet is 1.
- R4: The first 27 bit slots of every packet are output as 0, and the previous-bit state still follows the source bits through them.
- R5: With dbl_mode=0 at start the packet is 26 bytes (12 header + 14 payload). With dbl_mode=1 it is 40 bytes (12 header + 28 payload), and the encoding runs without restart across the two blocks.
- R6: From the cycle after an accepted start, pkt_len holds 26 or 40 and pkt_len_m1 holds that value minus one.
- R7: Upstream bytes are consumed only after all 12 header bytes are loaded. Exactly 14 or 28 bytes are consumed per packet.
- R8: While out_valid=1 and out_ready=0, out_data and out_valid stay unchanged, and no encoder state is lost.
- R9: A start pulse while busy=1 has no effect: the current packet, its mode and its length are unchanged.
- R10: Consecutive packets are independent. Each one restarts the previous-bit state at 1 and the suppression window at 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a packet; taken only when busy=0 |
| dbl_mode | input | 1 | 0 = one coded block, 1 = two, sampled with start |
| in_data | input | 8 | Upstream coded-block byte |
| in_valid | input | 1 | Upstream byte available |
| in_ready | output | 1 | Framer takes in_data this cycle |
| out_data | output | 8 | Encoded packet byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | FIFO side accepts out_data |
| busy | output | 1 | Packet in progress or last byte not yet taken |
| pkt_len | output | 6 | Total bytes of the current or last packet |
| pkt_len_m1 | output | 6 | pkt_len minus one, for the FIFO length field |

## Verification
The assertions assume that the sink follows valid/ready and never withdraws a byte it has seen, and that the upstream source only presents payload bytes while a packet is running. They also assume that start is the only way a packet begins, so the count of taken bytes can be cleared on an accepted start. The stimulus drives in_valid only while payload bytes remain for the current packet. It changes out_ready and in_valid only on the falling edge, and it varies both through steady, sparse and long-stall patterns. The one start pulse given mid-packet is issued while busy is high, which keeps that case inside the assumption.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int HDR_BYTES = 12;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pf_state_e;

    // fixed lead-in: alternating-bit run, then the sync word
    function automatic logic [7:0] hdr_lookup(input logic [3:0] pos);
        logic [7:0] v;
        case (pos)
            4'd7:    v = 8'h07;
            4'd8:    v = 8'h09;
            4'd9:    v = 8'h2A;
            4'd10:   v = 8'h44;
            4'd11:   v = 8'h6F;
            default: v = 8'h55;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pf_hdr_rom.sv
module pf_hdr_rom #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       hdr
);
    import pf_pkg::*;

    always_comb begin
        if (32'(idx) < HDR_BYTES) hdr = hdr_lookup(4'(idx));
        else                      hdr = 8'h00;
    end

endmodule

// File: rtl/pf_diff_enc.sv
module pf_diff_enc #(
    parameter int CW = 5
) (
    input  logic [7:0]    src,
    input  logic          prev_in,
    input  logic [CW-1:0] supp,
    output logic [7:0]    enc,
    output logic          prev_out
);
    // chain[k+1] is the bit that precedes src[k] in MSB-first order
    logic [8:0] chain;
    assign chain = {prev_in, src};

    for (genvar k = 0; k < 8; k++) begin : g_bit
        localparam int POS = 7 - k;
        logic open;
        assign open   = (POS >= 32'(supp));
        assign enc[k] = open & (src[k] ^ chain[k+1]);
    end

    assign prev_out = src[0];

endmodule

// File: rtl/pf_seq.sv
module pf_seq #(
    parameter int BLK_BYTES     = 14,
    parameter int SUPPRESS_BITS = 27,
    parameter int IDX_W         = 6,
    parameter int CW            = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dbl_mode,
    input  logic [7:0]       hdr_byte,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic [7:0]       enc_byte,
    input  logic             enc_last,
    output logic [IDX_W-1:0] idx,
    output logic [7:0]       src_byte,
    output logic             prev_bit,
    output logic [CW-1:0]    supp_cnt,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             busy,
    output logic [IDX_W-1:0] pkt_len,
    output logic [IDX_W-1:0] pkt_len_m1
);
    import pf_pkg::*;

    localparam logic [IDX_W-1:0] HDR_N   = IDX_W'(HDR_BYTES);
    localparam logic [IDX_W-1:0] TOT_ONE = IDX_W'(HDR_BYTES + BLK_BYTES);
    localparam logic [IDX_W-1:0] TOT_TWO = IDX_W'(HDR_BYTES + 2 * BLK_BYTES);
    localparam logic [CW-1:0]    SUPP_INIT = CW'(SUPPRESS_BITS);

    typedef struct packed {
        pf_state_e        st;
        logic             dbl;
        logic [IDX_W-1:0] idx;
        logic             prev;
        logic [CW-1:0]    supp;
        logic             ov;
        logic [7:0]       od;
        logic [IDX_W-1:0] len;
        logic [IDX_W-1:0] lenm1;
    } seq_t;

    seq_t q, d;
    logic in_hdr, can_load, src_ok, adv;
    logic [IDX_W-1:0] total_q, total_new;

    always_comb begin
        d         = q;
        in_hdr    = (q.idx < HDR_N);
        can_load  = !q.ov || out_ready;
        src_ok    = in_hdr || in_valid;
        total_q   = q.dbl ? TOT_TWO : TOT_ONE;
        total_new = dbl_mode ? TOT_TWO : TOT_ONE;
        adv       = (q.st == ST_RUN) && can_load && src_ok;

        if (q.ov && out_ready) d.ov = 1'b0;

        if (q.st == ST_IDLE) begin
            if (start && !q.ov) begin
                d.st    = ST_RUN;
                d.dbl   = dbl_mode;
                d.idx   = '0;
                d.prev  = 1'b1;
                d.supp  = SUPP_INIT;
                d.len   = total_new;
                d.lenm1 = total_new - IDX_W'(1);
            end
        end else if (adv) begin
            d.ov   = 1'b1;
            d.od   = enc_byte;
            d.prev = enc_last;
            if (32'(q.supp) > 8) d.supp = q.supp - CW'(8);
            else                 d.supp = '0;
            d.idx  = q.idx + IDX_W'(1);
            if (q.idx == total_q - IDX_W'(1)) d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.dbl   <= 1'b0;
            q.idx   <= '0;
            q.prev  <= 1'b1;
            q.supp  <= SUPP_INIT;
            q.ov    <= 1'b0;
            q.od    <= '0;
            q.len   <= '0;
            q.lenm1 <= '0;
        end else begin
            q <= d;
        end
    end

    assign idx        = q.idx;
    assign src_byte   = in_hdr ? hdr_byte : in_data;
    assign prev_bit   = q.prev;
    assign supp_cnt   = q.supp;
    assign in_ready   = (q.st == ST_RUN) && !in_hdr && can_load;
    assign out_valid  = q.ov;
    assign out_data   = q.od;
    assign busy       = (q.st == ST_RUN) || q.ov;
    assign pkt_len    = q.len;
    assign pkt_len_m1 = q.lenm1;

endmodule

// File: rtl/pf_framer.sv
module pf_framer #(
    parameter int BLK_BYTES     = 14,
    parameter int SUPPRESS_BITS = 27,
    localparam int MAX_BYTES    = pf_pkg::HDR_BYTES + 2 * BLK_BYTES,
    localparam int LEN_W        = $clog2(MAX_BYTES + 1),
    localparam int CW           = $clog2(SUPPRESS_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dbl_mode,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             busy,
    output logic [LEN_W-1:0] pkt_len,
    output logic [LEN_W-1:0] pkt_len_m1
);
    logic [LEN_W-1:0] idx;
    logic [7:0]       hdr_byte, src_byte, enc_byte;
    logic             prev_bit, enc_last;
    logic [CW-1:0]    supp_cnt;

    pf_hdr_rom #(.IDX_W(LEN_W)) u_rom (
        .idx (idx),
        .hdr (hdr_byte)
    );

    pf_diff_enc #(.CW(CW)) u_enc (
        .src      (src_byte),
        .prev_in  (prev_bit),
        .supp     (supp_cnt),
        .enc      (enc_byte),
        .prev_out (enc_last)
    );

    pf_seq #(
        .BLK_BYTES     (BLK_BYTES),
        .SUPPRESS_BITS (SUPPRESS_BITS),
        .IDX_W         (LEN_W),
        .CW            (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dbl_mode   (dbl_mode),
        .hdr_byte   (hdr_byte),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .enc_byte   (enc_byte),
        .enc_last   (enc_last),
        .idx        (idx),
        .src_byte   (src_byte),
        .prev_bit   (prev_bit),
        .supp_cnt   (supp_cnt),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .busy       (busy),
        .pkt_len    (pkt_len),
        .pkt_len_m1 (pkt_len_m1)
    );

endmodule

// File: rtl/pf_chk.sv
module pf_chk #(
    parameter int BLK_BYTES     = 14,
    parameter int SUPPRESS_BITS = 27,
    parameter int LEN_W         = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_ready,
    input logic [7:0]       out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic             busy,
    input logic [LEN_W-1:0] pkt_len,
    input logic [LEN_W-1:0] pkt_len_m1
);
    localparam int HDR       = pf_pkg::HDR_BYTES;
    localparam int ZERO_BYTS = SUPPRESS_BITS / 8;
    localparam int LEN_ONE   = HDR + BLK_BYTES;
    localparam int LEN_TWO   = HDR + 2 * BLK_BYTES;

    logic [LEN_W-1:0] taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      taken <= '0;
        else if (start && !busy)         taken <= '0;
        else if (out_valid && out_ready) taken <= taken + LEN_W'(1);
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

    AST_NO_EARLY_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> 32'(taken) >= HDR - 1); // R7

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(taken) <= 32'(pkt_len)); // R5

    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && 32'(taken) < ZERO_BYTS |-> out_data == 8'h00); // R4

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        start && busy |=> $stable(pkt_len)); // R9

    AST_LEN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(pkt_len) == LEN_ONE || 32'(pkt_len) == LEN_TWO)
                 && pkt_len_m1 == pkt_len - LEN_W'(1)); // R6

endmodule

bind pf_framer pf_chk #(
    .BLK_BYTES     (BLK_BYTES),
    .SUPPRESS_BITS (SUPPRESS_BITS),
    .LEN_W         (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_ready   (in_ready),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .busy       (busy),
    .pkt_len    (pkt_len),
    .pkt_len_m1 (pkt_len_m1)
);

// File: tb/sim_pf_framer.sv
`timescale 1ns/1ps
module sim_pf_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dbl_mode = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       busy;
    logic [5:0] pkt_len, pkt_len_m1;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] hdr_ref [0:11];
    logic [7:0] payload [0:27];
    logic [7:0] srcb    [0:39];
    logic [7:0] expb    [0:39];
    logic [7:0] got     [0:39];

    always #2.5 clk = ~clk;

    pf_framer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dbl_mode(dbl_mode),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .busy(busy), .pkt_len(pkt_len), .pkt_len_m1(pkt_len_m1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bit-serial reference: 1 on change, first 27 slots held at 0, state starts at 1
    task automatic build_exp(input bit dbl);
        int total = dbl ? 40 : 26;
        bit p = 1'b1;
        for (int i = 0; i < 12; i++) srcb[i] = hdr_ref[i];
        for (int i = 12; i < total; i++) srcb[i] = payload[i-12];
        for (int i = 0; i < total; i++) begin
            expb[i] = 8'h00;
            for (int b = 7; b >= 0; b--) begin
                int g = i * 8 + (7 - b);
                if (g >= 27 && srcb[i][b] != p) expb[i][b] = 1'b1;
                p = srcb[i][b];
            end
        end
    endtask

    task automatic run_pkt(input bit dbl, input int seed, input int pat,
                           input bit poke, input string tag);
        int total = dbl ? 40 : 26;
        int nin   = dbl ? 28 : 14;
        int gc = 0, ptr = 0, cyc = 0;
        bit stl = 1'b0, early = 1'b0;
        logic [7:0] stv = 8'h00;
        for (int k = 0; k < 28; k++) payload[k] = 8'((seed * 37 + k * 11 + k * k) & 255);
        build_exp(dbl);
        @(negedge clk);
        start = 1'b1; dbl_mode = dbl;
        @(negedge clk);
        start = 1'b0;
        check(pkt_len == 6'(total), {tag, " R6 len"}, pkt_len, total);
        check(pkt_len_m1 == 6'(total - 1), {tag, " R6 len_m1"}, pkt_len_m1, total - 1);
        while (gc < total && cyc < 3000) begin
            if (cyc > 0) @(negedge clk);
            case (pat)
                1:       out_ready = (cyc % 3) != 0;
                2:       out_ready = (cyc % 7) >= 4;
                default: out_ready = 1'b1;
            endcase
            in_valid = (ptr < nin) && !(pat == 2 && (cyc % 5) == 1);
            in_data  = (ptr < nin) ? payload[ptr] : 8'h00;
            start    = poke && (cyc == 20);
            dbl_mode = poke && (cyc == 20) ? !dbl : dbl;
            #1;
            if (stl)
                check(out_valid && out_data == stv, {tag, " R8 hold"}, out_data, stv);
            stl = out_valid && !out_ready;
            stv = out_data;
            if (in_ready && gc < 11) early = 1'b1;
            if (out_valid && out_ready) begin got[gc] = out_data; gc++; end
            if (in_valid && in_ready) ptr++;
            cyc++;
        end
        start = 1'b0; in_valid = 1'b0;
        check(gc == total, {tag, " R5 count"}, gc, total);
        check(ptr == nin, {tag, " R7 consumed"}, ptr, nin);
        check(!early, {tag, " R7 header first"}, early, 0);
        for (int i = 0; i < gc; i++) begin
            if (i < 4)       check(got[i] == expb[i], {tag, " R4 lead"}, got[i], expb[i]);
            else if (i < 12) check(got[i] == expb[i], {tag, " R2 header"}, got[i], expb[i]);
            else             check(got[i] == expb[i], {tag, " R3 payload"}, got[i], expb[i]);
        end
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        check(!busy && !out_valid, {tag, " R9 idle after"}, busy, 0);
        if (poke) check(pkt_len == 6'(total), {tag, " R9 len kept"}, pkt_len, total);
    endtask

    task automatic test_reset();
        check(!out_valid && !in_ready && !busy, "R1 reset", {out_valid, in_ready, busy}, 0);
    endtask

    initial begin
        hdr_ref[0] = 8'h55; hdr_ref[1] = 8'h55; hdr_ref[2] = 8'h55; hdr_ref[3] = 8'h55;
        hdr_ref[4] = 8'h55; hdr_ref[5] = 8'h55; hdr_ref[6] = 8'h55; hdr_ref[7] = 8'h07;
        hdr_ref[8] = 8'h09; hdr_ref[9] = 8'h2A; hdr_ref[10] = 8'h44; hdr_ref[11] = 8'h6F;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_pkt(1'b0, 1, 0, 1'b0, "single steady R5");
        run_pkt(1'b1, 2, 0, 1'b0, "double steady R5");
        run_pkt(1'b1, 3, 1, 1'b0, "double sparse R8");
        run_pkt(1'b0, 4, 2, 1'b0, "single stall R8");
        run_pkt(1'b0, 5, 1, 1'b1, "start while busy R9");
        run_pkt(1'b1, 6, 2, 1'b1, "double poke R9");
        run_pkt(1'b0, 7, 0, 1'b0, "back to back A R10");
        run_pkt(1'b0, 7, 0, 1'b0, "back to back B R10");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule